// File: doc/BRIEF.md
# Receiver Error Flag Controller

This block drives the error flag of a digital audio interface receiver. Its inputs are ready-made strobes from the rest of the receiver: a lock indicator from the PLL, a data error strobe, a per-sub-frame parity result, a non-PCM detect level, a strobe for each block-start (preamble B), and fs-change pulses from two sources, measured and channel-status. From these it produces a registered error flag, a mute request for the audio data path and a select that moves the recovered clock over to the crystal once a programmable wait after unlock has run out.

After lock is gained, the flag stays high until a programmable number of block starts has been counted. Once that count is reached the receiver is considered settled. The flag can be set to include non-PCM data or to leave it out. It can also be forced high. Runs of parity errors are reported in one of two styles, and measured fs changes can be ignored. All of these settings sit in one 16-bit control word. The word is written through a plain write port and is taken only when its low byte carries this command's code.

Top module: `rx_errflag_ctrl`

## Requirements
- R1: A write is accepted only when wr_data[7:2] is 6'b100100 and wr_data[1:0] equals EXT_ID (default 2'b00). Other writes leave the settings unchanged. The high byte maps as follows: [15:14] release select, [13] fs ignore, [12] force, [11:10] wait select, [9] parity sub-frame mode, [8] non-PCM enable. Every setting is 0 after reset. An accepted write takes effect from the next cycle.
- R2: After reset, err_flag is 1. While pll_locked is high, each preamble_b strobe is counted. When the count reaches the release target, err_flag falls at the second rising edge after that strobe. The target is 48, 24, 12 or 6 for release select 00, 01, 10 or 11.
- R3: If pll_locked is low at a rising edge, err_flag is 1 after that edge and the release count starts again from zero.
- R4: A data_err strobe sets err_flag for the cycle after it. nonpcm sets err_flag only when non-PCM enable is 1.
- R5: mute_req is 1 in the cycle after any cycle in which nonpcm and non-PCM enable are both 1, and 0 otherwise. The force setting does not change it.
- R6: When the force setting is 1, err_flag is held at 1. mute_req and xtal_sel carry on unchanged.
- R7: A measured fs change (fs_chg_meas) sets err_flag and restarts the release count, but only while fs ignore is 0. A channel-status fs change (fs_chg_cs) does the same whatever fs ignore is set to.
- R8: parity_err is valid together with subframe. A good sub-frame clears the run count, and the count saturates at 8. With parity sub-frame mode 0, err_flag is set while the run count is 8 and nonpcm is 1.
- R9: With parity sub-frame mode 1, err_flag is set for one cycle after each bad sub-frame that takes the run to 8 or keeps it there. This does not depend on nonpcm.
- R10: While unlocked, an osc_start pulse starts a wait measured in us_tick pulses. The length is 200, 100, 50 or 400 ticks for wait select 00, 01, 10 or 11 (WAIT_BASE=50). On the tick that completes the wait, xtal_sel goes to 1.
- R11: While pll_locked is 1, xtal_sel is 0 and any pending wait is dropped. A new osc_start during a wait starts the count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| osc_start | input | 1 | Pulse: crystal oscillator amplifier started |
| pll_locked | input | 1 | PLL lock level |
| data_err | input | 1 | Data error strobe |
| subframe | input | 1 | Sub-frame end strobe |
| parity_err | input | 1 | Parity bad for this sub-frame (valid with subframe) |
| nonpcm | input | 1 | Non-PCM data detected level |
| preamble_b | input | 1 | Block-start preamble strobe |
| fs_chg_meas | input | 1 | Measured fs change pulse |
| fs_chg_cs | input | 1 | Channel-status fs change pulse |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word |
| err_flag | output | 1 | Registered error flag |
| mute_req | output | 1 | Audio mute request |
| xtal_sel | output | 1 | 1 selects the crystal clock |

## Verification
Two functions can act in the same cycle: a restart of the release count caused by an fs change or by a lock drop, and the preamble_b strobe that would have completed the release. The bench provokes this by driving fs-change pulses and lock drops in the middle of preamble runs. A reference model steps through every cycle with plain integer counters and is compared against the block on each clock, so it must agree on whether the count restarted or the release happened. A second overlap is a fresh osc_start landing during a running clock-switch wait. It is judged the same way, and an explicit check confirms that xtal_sel has not yet risen at the point where the original wait would have ended.

// File: rtl/rx_errflag_pkg.sv
// Package: shared settings type and command code for the error flag controller.
// Assumes the high byte of the control word is laid out MSB-first exactly as efc_cfg_t.
package rx_errflag_pkg;
    typedef struct packed {
        logic [1:0] rel_sel;      // release count select
        logic       fs_ignore;    // ignore measured fs change
        logic       force_err;    // hold flag high
        logic [1:0] wait_sel;     // clock switch wait select
        logic       par_sub_only; // parity run reported per sub-frame
        logic       nonpcm_en;    // non-PCM enters the flag
    } efc_cfg_t;

    localparam logic [5:0] CMD_CODE = 6'b100100;
endpackage

// File: rtl/rxef_cfg_reg.sv
// Settings register: captures the high byte of a write whose low byte carries
// the command code and the address extension. Assumes single-cycle wr_en strobes.
module rxef_cfg_reg
    import rx_errflag_pkg::*;
#(
    parameter logic [1:0] EXT_ID = 2'b00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [15:0]     wr_data,
    output efc_cfg_t        cfg
);
    logic hit;

    // Decode: command code and extension must both match.
    always_comb hit = wr_en && (wr_data[7:2] == CMD_CODE) && (wr_data[1:0] == EXT_ID);

    // Capture settings on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)   cfg <= '0;
        else if (hit) cfg <= efc_cfg_t'(wr_data[15:8]);
    end
endmodule

// File: rtl/rxef_release.sv
// Release counter: counts block-start strobes while locked, then asserts
// released until lock is lost or a restart is requested. Target = REL_BASE >> sel.
module rxef_release #(
    parameter int REL_BASE = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       locked,
    input  logic       restart,
    input  logic       pre_b,
    input  logic [1:0] rel_sel,
    output logic       released
);
    localparam int RW = $clog2(REL_BASE + 1);
    localparam logic [RW-1:0] BASE = RW'(REL_BASE);

    logic [RW-1:0] cnt;
    logic [RW-1:0] target;

    // Target count for the selected code.
    always_comb target = BASE >> rel_sel;

    // Count strobes; restart on unlock or restart request.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked || restart) begin
            cnt      <= '0;
            released <= 1'b0;
        end else if (!released && pre_b) begin
            if (cnt == target - RW'(1)) released <= 1'b1;
            else                        cnt      <= cnt + RW'(1);
        end
    end
endmodule

// File: rtl/rxef_parity_run.sv
// Parity run counter: counts consecutive bad sub-frames, saturating at RUN_LEN,
// cleared by a good one. run_hit marks a bad sub-frame that reaches or holds RUN_LEN.
module rxef_parity_run #(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic subframe,
    input  logic parity_err,
    output logic run_full,
    output logic run_hit
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

    logic [CW-1:0] cnt;

    // Status views of the run counter.
    always_comb begin
        run_full = (cnt == FULL);
        run_hit  = subframe && parity_err && (cnt >= FULL - CW'(1));
    end

    // Advance, saturate or clear on each sub-frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (subframe && !parity_err) cnt <= '0;
        else if (subframe && !run_full)  cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/rxef_clk_switch.sv
// Clock switch timer: after an oscillator start while unlocked, waits a number of
// microsecond ticks (4,2,1,8 x WAIT_BASE by code) and then selects the crystal.
module rxef_clk_switch #(
    parameter int WAIT_BASE = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       locked,
    input  logic       osc_start,
    input  logic       us_tick,
    input  logic [1:0] wait_sel,
    output logic       xtal_sel
);
    localparam int TW = $clog2(8 * WAIT_BASE + 1);

    logic          waiting;
    logic [TW-1:0] tcnt;
    logic [TW-1:0] limit;

    // Wait length in ticks for the selected code.
    always_comb begin
        case (wait_sel)
            2'b00:   limit = TW'(4 * WAIT_BASE);
            2'b01:   limit = TW'(2 * WAIT_BASE);
            2'b10:   limit = TW'(WAIT_BASE);
            default: limit = TW'(8 * WAIT_BASE);
        endcase
    end

    // Wait sequencing; lock cancels everything.
    always_ff @(posedge clk) begin
        if (!rst_n || locked) begin
            waiting  <= 1'b0;
            tcnt     <= '0;
            xtal_sel <= 1'b0;
        end else if (osc_start) begin
            waiting <= 1'b1;
            tcnt    <= '0;
        end else if (waiting && us_tick) begin
            if (tcnt == limit - TW'(1)) begin
                waiting  <= 1'b0;
                xtal_sel <= 1'b1;
            end else begin
                tcnt <= tcnt + TW'(1);
            end
        end
    end
endmodule

// File: rtl/rx_errflag_ctrl.sv
// Top: combines lock release, data error, non-PCM, parity run and fs change
// into a registered error flag; also drives the mute request and clock select.
// Assumes all strobes are single-cycle and synchronous to clk.
module rx_errflag_ctrl
    import rx_errflag_pkg::*;
#(
    parameter int         REL_BASE  = 48,
    parameter int         RUN_LEN   = 8,
    parameter int         WAIT_BASE = 50,
    parameter logic [1:0] EXT_ID    = 2'b00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        us_tick,
    input  logic        osc_start,
    input  logic        pll_locked,
    input  logic        data_err,
    input  logic        subframe,
    input  logic        parity_err,
    input  logic        nonpcm,
    input  logic        preamble_b,
    input  logic        fs_chg_meas,
    input  logic        fs_chg_cs,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic        err_flag,
    output logic        mute_req,
    output logic        xtal_sel
);
    efc_cfg_t cfg_q;
    logic     fs_evt;
    logic     released;
    logic     run_full;
    logic     run_hit;
    logic     par_term;
    logic     err_d;

    rxef_cfg_reg #(.EXT_ID(EXT_ID)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cfg(cfg_q)
    );

    rxef_release #(.REL_BASE(REL_BASE)) u_rel (
        .clk(clk), .rst_n(rst_n), .locked(pll_locked), .restart(fs_evt),
        .pre_b(preamble_b), .rel_sel(cfg_q.rel_sel), .released(released)
    );

    rxef_parity_run #(.RUN_LEN(RUN_LEN)) u_par (
        .clk(clk), .rst_n(rst_n), .subframe(subframe), .parity_err(parity_err),
        .run_full(run_full), .run_hit(run_hit)
    );

    rxef_clk_switch #(.WAIT_BASE(WAIT_BASE)) u_sw (
        .clk(clk), .rst_n(rst_n), .locked(pll_locked), .osc_start(osc_start),
        .us_tick(us_tick), .wait_sel(cfg_q.wait_sel), .xtal_sel(xtal_sel)
    );

    // Error sources merged into the next flag value.
    always_comb begin
        fs_evt   = fs_chg_cs || (fs_chg_meas && !cfg_q.fs_ignore);
        par_term = cfg_q.par_sub_only ? run_hit : (run_full && nonpcm);
        err_d    = cfg_q.force_err || !pll_locked || !released || data_err ||
                   (cfg_q.nonpcm_en && nonpcm) || fs_evt || par_term;
    end

    // Output registers for flag and mute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b1;
            mute_req <= 1'b0;
        end else begin
            err_flag <= err_d;
            mute_req <= cfg_q.nonpcm_en && nonpcm;
        end
    end
endmodule

// File: rtl/rx_errflag_ctrl_chk.sv
// Checker: temporal properties on the error flag controller's ports and settings.
module rx_errflag_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic pll_locked,
    input logic nonpcm,
    input logic force_err,
    input logic err_flag,
    input logic mute_req,
    input logic xtal_sel
);
    assert_unlock_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> err_flag);
    assert_release_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> $past(pll_locked));
    assert_force_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        force_err |=> err_flag);
    assert_mute_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_req) |-> $past(nonpcm));
    assert_switch_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xtal_sel) |-> $past(!pll_locked));
    assert_lock_cancels_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pll_locked |=> !xtal_sel);
endmodule

bind rx_errflag_ctrl rx_errflag_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .nonpcm(nonpcm),
    .force_err(cfg_q.force_err), .err_flag(err_flag), .mute_req(mute_req),
    .xtal_sel(xtal_sel)
);

// File: tb/rx_errflag_ctrl_bench.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module rx_errflag_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0, osc_start = 1'b0, pll_locked = 1'b0, data_err = 1'b0;
    logic subframe = 1'b0, parity_err = 1'b0, nonpcm = 1'b0, preamble_b = 1'b0;
    logic fs_chg_meas = 1'b0, fs_chg_cs = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic err_flag, mute_req, xtal_sel;

    int n_chk = 0, n_fail = 0, tick_ctr = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    int m_rel_sel = 0, m_fs_ign = 0, m_force = 0, m_wait_sel = 0, m_sub = 0, m_npen = 0;
    int m_cnt = 0, m_rel = 0, m_par = 0, m_wait = 0, m_tcnt = 0;
    bit m_flag = 1, m_mute = 0, m_xtal = 0;

    always #2.5 clk = ~clk;

    rx_errflag_ctrl u_rx_errflag_ctrl (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .osc_start(osc_start),
        .pll_locked(pll_locked), .data_err(data_err), .subframe(subframe),
        .parity_err(parity_err), .nonpcm(nonpcm), .preamble_b(preamble_b),
        .fs_chg_meas(fs_chg_meas), .fs_chg_cs(fs_chg_cs), .wr_en(wr_en),
        .wr_data(wr_data), .err_flag(err_flag), .mute_req(mute_req), .xtal_sel(xtal_sel)
    );

    // Reference model, one step per rising edge.
    always @(posedge clk) begin
        int tgt, lim, fsev, hit, pterm, nflag;
        if (!rst_n) begin
            m_rel_sel = 0; m_fs_ign = 0; m_force = 0; m_wait_sel = 0; m_sub = 0; m_npen = 0;
            m_cnt = 0; m_rel = 0; m_par = 0; m_wait = 0; m_tcnt = 0;
            m_flag = 1; m_mute = 0; m_xtal = 0;
        end else begin
            tgt   = 48 / (1 << m_rel_sel);
            lim   = (m_wait_sel == 0) ? 200 : (m_wait_sel == 1) ? 100 : (m_wait_sel == 2) ? 50 : 400;
            fsev  = fs_chg_cs || (fs_chg_meas && m_fs_ign == 0);
            hit   = subframe && parity_err && m_par >= 7;
            pterm = m_sub ? hit : (m_par == 8 && nonpcm);
            nflag = m_force || !pll_locked || !m_rel || data_err || (m_npen && nonpcm) || fsev || pterm;
            m_flag = nflag[0];
            m_mute = m_npen && nonpcm;
            if (!pll_locked || fsev) begin m_cnt = 0; m_rel = 0; end
            else if (!m_rel && preamble_b) begin
                if (m_cnt == tgt - 1) m_rel = 1; else m_cnt++;
            end
            if (subframe && !parity_err) m_par = 0;
            else if (subframe && m_par < 8) m_par++;
            if (pll_locked) begin m_wait = 0; m_tcnt = 0; m_xtal = 0; end
            else if (osc_start) begin m_wait = 1; m_tcnt = 0; end
            else if (m_wait && us_tick) begin
                if (m_tcnt == lim - 1) begin m_wait = 0; m_xtal = 1; end else m_tcnt++;
            end
            if (wr_en && wr_data[7:0] == 8'b1001_0000) begin
                m_rel_sel = wr_data[15:14]; m_fs_ign = wr_data[13]; m_force = wr_data[12];
                m_wait_sel = wr_data[11:10]; m_sub = wr_data[9]; m_npen = wr_data[8];
            end
        end
    end

    // Compare with the model at each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if ({err_flag, mute_req, xtal_sel} !== {m_flag, m_mute, m_xtal}) begin
                n_fail++;
                $display("FAIL %s model compare: actual flag/mute/xtal=%b expected=%b", tag,
                         {err_flag, mute_req, xtal_sel}, {m_flag, m_mute, m_xtal});
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
        data_err = 0; subframe = 0; parity_err = 0; preamble_b = 0;
        fs_chg_meas = 0; fs_chg_cs = 0; wr_en = 0; osc_start = 0;
        tick_ctr++;
        us_tick = (tick_ctr % 4 == 0);
    endtask

    task automatic cycs(input int n);
        repeat (n) cyc();
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1; wr_data = d; cyc();
    endtask

    task automatic pre(input int n);
        repeat (n) begin preamble_b = 1; cyc(); cyc(); end
    endtask

    task automatic relock();
        pll_locked = 0; cyc(); pll_locked = 1; cyc();
    endtask

    task automatic sub(input int n, input logic bad);
        repeat (n) begin subframe = 1; parity_err = bad; cyc(); cyc(); end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired in %s", tag);
        finish_run();
    end

    initial begin
        tag = "R1"; cycs(3); rst_n = 1; cyc();
        chk(err_flag, 1'b1, "reset flag"); chk(mute_req, 1'b0, "reset mute"); chk(xtal_sel, 1'b0, "reset xtal");

        tag = "R2"; pll_locked = 1; cyc(); pre(47); cyc();
        chk(err_flag, 1'b1, "flag before 48th preamble");
        pre(1); cyc(); chk(err_flag, 1'b0, "flag after 48th preamble");

        tag = "R3"; pll_locked = 0; cyc(); chk(err_flag, 1'b1, "flag on unlock");
        pll_locked = 1; pre(20); pll_locked = 0; cyc(); pll_locked = 1; pre(47);
        chk(err_flag, 1'b1, "count restarted"); pre(2); chk(err_flag, 1'b0, "released again");

        tag = "R1"; wr(16'hC000); wr(16'hC091); relock(); pre(7);
        chk(err_flag, 1'b1, "bad writes ignored, 48 still needed");
        wr(16'hC090); relock(); pre(6); chk(err_flag, 1'b0, "code 11 releases after 6");

        tag = "R4"; data_err = 1; cyc(); chk(err_flag, 1'b1, "data error"); cyc();
        chk(err_flag, 1'b0, "data error one cycle");
        nonpcm = 1; cycs(3); chk(err_flag, 1'b0, "nonpcm excluded");
        wr(16'h4190); cycs(2); chk(err_flag, 1'b1, "nonpcm included");
        tag = "R5"; chk(mute_req, 1'b1, "mute on nonpcm");

        tag = "R6"; wr(16'h5190); cycs(2); nonpcm = 0; cycs(3);
        chk(err_flag, 1'b1, "forced flag"); chk(mute_req, 1'b0, "mute follows nonpcm under force");
        nonpcm = 1; cycs(2); chk(mute_req, 1'b1, "mute under force"); nonpcm = 0;
        wr(16'h4090); cycs(2); chk(err_flag, 1'b0, "force released");

        tag = "R7"; pre(3); fs_chg_meas = 1; cyc(); chk(err_flag, 1'b1, "measured fs change");
        pre(23); chk(err_flag, 1'b1, "release restarted"); pre(1); cyc(); chk(err_flag, 1'b0, "released");
        wr(16'h6090); cyc(); fs_chg_meas = 1; cyc(); chk(err_flag, 1'b0, "measured fs ignored");
        preamble_b = 1; fs_chg_cs = 1; cyc(); chk(err_flag, 1'b1, "cs fs change with preamble");
        pre(24); chk(err_flag, 1'b0, "released after cs change");

        tag = "R8"; wr(16'h4090); nonpcm = 1; sub(7, 1); chk(err_flag, 1'b0, "7 bad");
        sub(1, 1); chk(err_flag, 1'b1, "8 bad with nonpcm"); sub(3, 1);
        nonpcm = 0; cycs(2); chk(err_flag, 1'b0, "run needs nonpcm"); nonpcm = 1; cyc();
        sub(1, 0); chk(err_flag, 1'b0, "good sub-frame clears"); nonpcm = 0;

        tag = "R9"; wr(16'h4290); sub(7, 1); subframe = 1; parity_err = 1; cyc();
        chk(err_flag, 1'b1, "8th bad pulse"); cyc(); chk(err_flag, 1'b0, "pulse one cycle");
        sub(3, 1); sub(1, 0); sub(7, 1); chk(err_flag, 1'b0, "cleared run");

        tag = "R10";
        for (int c = 0; c < 4; c++) begin
            int lim;
            lim = (c == 0) ? 200 : (c == 1) ? 100 : (c == 2) ? 50 : 400;
            wr(16'h4090 | 16'(c << 10)); pll_locked = 0; cyc(); osc_start = 1; cyc();
            cycs(4 * lim - 12); chk(xtal_sel, 1'b0, "before wait end");
            cycs(16); chk(xtal_sel, 1'b1, "after wait end");
            pll_locked = 1; cyc(); chk(xtal_sel, 1'b0, "relock restores");
        end

        tag = "R11"; wr(16'h4890); pll_locked = 0; cyc(); osc_start = 1; cyc();
        cycs(100); osc_start = 1; cyc(); cycs(150); chk(xtal_sel, 1'b0, "restart on new osc start");
        cycs(100); chk(xtal_sel, 1'b1, "switch after restart");
        pll_locked = 1; cyc(); pll_locked = 0; osc_start = 1; cyc(); cycs(100);
        pll_locked = 1; cyc(); pll_locked = 0; cycs(300); chk(xtal_sel, 1'b0, "relock cancelled wait");
        pll_locked = 1; cycs(3);
        finish_run();
    end
endmodule